// File: doc/BRIEF.md
# Configuration Header Register File (Type-0 Function)

This block is the target-side register file for the configuration space of one bus function. The space is 256 bytes. The first 64 bytes hold the standard type-0 header: identity words, the command and status pair, class and revision, header type, six base address registers, an expansion-ROM base and the interrupt byte group. Any other offset reads as zero. Requests arrive as a dword index with four byte-lane enables. A read returns its data one clock later. A write takes effect at the clock edge that accepts it.

Each field has its own access rule. Some fields are fixed by parameters. Some are plain storage. The error flags in the status word are set by hardware event inputs and cleared by writing a one. In a base register, every address bit below the region size is hard-wired to zero. Software can therefore write all ones and read back the size. The command enables, the decoded BAR bases, the ROM enable and the ROM base leave the block as outputs. The rest of the device uses them for its own address decoding.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: Dword 0 reads {device id, vendor id} from parameters, neither of which may be FFFFh. Dword 2 reads {class code, revision}. Dword 3 carries the header type in bits 23:16 and zero elsewhere. Writes to these dwords change nothing.
- R2: The command word sits in dword 1, bits 15:0. Only bits 0, 1, 3, 5, 6, 8 and 9 store written values, and every other command bit reads zero. Bit 0 drives `io_space_en`, bit 1 drives `mem_space_en`, bit 6 drives `parity_resp_en` and bit 8 drives `serr_en`.
- R3: Dword 1 bit 23 (status bit 7) reads the fast back-to-back parameter. Bits 26:25 (status 10:9) read the select-timing code: 0 means fast, 1 medium, 2 slow. Writes do not alter any of these bits.
- R4: Dword 1 bits 27, 28 and 29 (status 11, 12 and 13) are set in the clock after `ev_tabort_sent`, `ev_tabort_rcvd` or `ev_mabort` respectively is high. A write with lane 3 enabled and a one in a flag's position clears that flag. Writing a zero leaves it alone. If an event and a clear hit the same flag in one cycle, the flag ends set.
- R5: BARs sit at dwords 4 through 9. Bit 0 reads 1 for an I/O region. Bits 2:1 read the locatable type. Bit 3 reads the prefetchable flag. Address bits below the region size read zero, so writing FFFFFFFFh reads back the size mask. A BAR with size 0 reads zero in every bit.
- R6: The ROM base sits at dword 12. Bit 0 is the decode enable and drives `rom_decode_en`. Bits 14:11 read the size code (0 = 32K, 1 = 64K, 2 = 128K, 3 = 256K). Base bits from 15+code up to 31 are writable, and every other bit reads zero. `rom_base_addr` carries the writable base bits.
- R7: In dword 15, bits 7:0 are the writable interrupt line. Bits 15:8 (pin), 23:16 (minimum grant) and 31:24 (maximum latency) read parameter values.
- R8: A write changes only the bytes whose lane enable is set. Lane n covers bits 8n+7:8n.
- R9: Every dword index other than 0–4, 5–9, 12 and 15 reads zero, and writes to it leave all state and outputs unchanged.
- R10: `rsp_valid` is high in exactly the cycle after a read request. `rsp_rdata` then holds the register value as it stood before that edge. Writes produce no response.
- R11: After reset the following read zero: the command word, the status flags, every BAR address field, the ROM enable, the ROM base and the interrupt line.
- R12: `bar_base_flat` slice i (bits 32i+31:32i) equals the address bits of BAR i with its low attribute bits zero. An absent BAR gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 6 | Dword index into the 256-byte space |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ev_tabort_sent | input | 1 | Event: target abort signalled |
| ev_tabort_rcvd | input | 1 | Event: target abort received |
| ev_mabort | input | 1 | Event: master abort |
| io_space_en | output | 1 | Command: respond to I/O requests |
| mem_space_en | output | 1 | Command: respond to memory requests |
| parity_resp_en | output | 1 | Command: parity error response |
| serr_en | output | 1 | Command: system error driver enable |
| rom_decode_en | output | 1 | ROM decode enable |
| rom_base_addr | output | 32 | ROM base, low bits zero |
| bar_base_flat | output | 192 | Six BAR bases, 32 bits each |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:

- **Size probe.** After writing all ones to every BAR and to the ROM base, each value read back must show the size mask with the attribute bits intact. A design that stores low address bits would return a smaller mask. A design that lets the attribute bits be written would corrupt the region type.
- **Status flag race.** An event and a clear of the same flag land in one cycle. A design that gives the clear priority loses the error.
- **Write-one-to-clear direction.** A clear is written with lane 3 disabled, and zeros are written to set flags. A design that ignores lane enables, or that clears on zero, would wipe flags.
- **Reserved space and partial lanes.** Writes to unimplemented dwords and partial-lane writes must leave the outputs unchanged. A stray decode would show up on the enables or the BAR buses.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   localparam int unsigned CFG_BYTES = 256;
   localparam int unsigned DW_COUNT  = CFG_BYTES / 4;
   localparam int unsigned IDX_W     = $clog2(DW_COUNT);
   localparam int unsigned NUM_BARS  = 6;
   localparam int unsigned SZ_W      = 6;

   localparam logic [IDX_W-1:0] IX_IDENT  = IDX_W'(0);
   localparam logic [IDX_W-1:0] IX_CMDSTS = IDX_W'(1);
   localparam logic [IDX_W-1:0] IX_CLASS  = IDX_W'(2);
   localparam logic [IDX_W-1:0] IX_HDR    = IDX_W'(3);
   localparam logic [IDX_W-1:0] IX_BAR0   = IDX_W'(4);
   localparam logic [IDX_W-1:0] IX_ROM    = IDX_W'(12);
   localparam logic [IDX_W-1:0] IX_INTR   = IDX_W'(15);

   localparam logic [15:0] CMD_STORE_MASK = 16'h036B;
   localparam int unsigned ROM_MIN_LOG2   = 15;
   localparam int unsigned EVT_LSB        = 27;
   localparam int unsigned NUM_EVT        = 3;

   function automatic logic [31:0] lane_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
      return m;
   endfunction

endpackage

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
   parameter int unsigned SIZE_LOG2 = 12,
   parameter bit          IS_IO     = 1'b0,
   parameter bit          PREFETCH  = 1'b0,
   parameter logic [1:0]  LOC_TYPE  = 2'b00
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rd_value,
   output logic [31:0] base_addr
);

   initial begin
      assert (SIZE_LOG2 == 0 || (SIZE_LOG2 >= 4 && SIZE_LOG2 <= 31))
         else $error("cfg_bar_slot: region size exponent out of range");
   end

   if (SIZE_LOG2 == 0) begin : g_absent
      logic unused_bar;
      assign unused_bar = ^{clk, rst_n, wr_en, be, wdata};
      assign rd_value   = '0;
      assign base_addr  = '0;
   end else begin : g_present
      localparam int unsigned AW = 32 - SIZE_LOG2;
      localparam logic [3:0]  ATTR = IS_IO ? 4'b0001 : {PREFETCH, LOC_TYPE, 1'b0};

      logic [AW-1:0] addr_q;
      logic [31:0]   cur;
      logic [31:0]   bmask;
      logic [31:0]   merged;
      logic          unused_low;

      assign cur        = {addr_q, {SIZE_LOG2{1'b0}}};
      assign bmask      = cfg_hdr_pkg::lane_mask(be);
      assign merged     = (wdata & bmask) | (cur & ~bmask);
      assign unused_low = ^merged[SIZE_LOG2-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     addr_q <= '0;
         else if (wr_en) addr_q <= merged[31:SIZE_LOG2];
      end

      assign rd_value  = cur | {28'b0, ATTR};
      assign base_addr = cur;

      // R5
      bar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en |=> $stable(base_addr));

      // R8
      bar_lane3_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !be[3]) |=> $stable(base_addr[31:24]));
   end

endmodule

// File: rtl/cfg_rom_slot.sv
module cfg_rom_slot #(
   parameter int unsigned SIZE_CODE = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rd_value,
   output logic [31:0] base_addr,
   output logic        decode_en
);

   localparam int unsigned LOW = cfg_hdr_pkg::ROM_MIN_LOG2 + SIZE_CODE;
   localparam int unsigned AW  = 32 - LOW;

   initial begin
      assert (SIZE_CODE <= 3) else $error("cfg_rom_slot: size code must be 0..3");
   end

   logic [AW-1:0] addr_q;
   logic          en_q;
   logic [31:0]   cur;
   logic [31:0]   bmask;
   logic [31:0]   merged;
   logic          unused_low;

   assign cur        = {addr_q, {LOW{1'b0}}};
   assign bmask      = cfg_hdr_pkg::lane_mask(be);
   assign merged     = (wdata & bmask) | (cur & ~bmask);
   assign unused_low = ^merged[LOW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         en_q   <= 1'b0;
      end else if (wr_en) begin
         addr_q <= merged[31:LOW];
         if (be[0]) en_q <= wdata[0];
      end
   end

   assign rd_value  = cur | (32'(SIZE_CODE) << 11) | {31'b0, en_q};
   assign base_addr = cur;
   assign decode_en = en_q;

   // R6
   rom_en_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(decode_en) |-> $past(wr_en && be[0] && wdata[0]));

   // R6
   rom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(base_addr) && $stable(decode_en)));

endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status #(
   parameter bit         FAST_B2B   = 1'b0,
   parameter logic [1:0] SEL_TIMING = 2'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   input  logic [cfg_hdr_pkg::NUM_EVT-1:0] events,
   output logic [31:0] rd_value,
   output logic [15:0] cmd
);
   import cfg_hdr_pkg::*;

   initial begin
      assert (SEL_TIMING != 2'd3) else $error("cfg_cmd_status: select timing code 3 is reserved");
   end

   logic [15:0]        cmd_q;
   logic [NUM_EVT-1:0] evt_q;
   logic [31:0]        bmask;
   logic [15:0]        cmd_wr;
   logic [NUM_EVT-1:0] clr;
   logic [15:0]        sts;
   logic               unused_wd;

   assign bmask  = lane_mask(be);
   assign cmd_wr = bmask[15:0] & CMD_STORE_MASK;
   assign clr    = (wr_en && be[3]) ? wdata[EVT_LSB +: NUM_EVT] : '0;
   assign unused_wd = ^{wdata[31:EVT_LSB+NUM_EVT], wdata[EVT_LSB-1:16], be[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         evt_q <= '0;
      end else begin
         if (wr_en) cmd_q <= (cmd_q & ~cmd_wr) | (wdata[15:0] & cmd_wr);
         evt_q <= events | (evt_q & ~clr);
      end
   end

   assign sts      = {2'b00, evt_q, SEL_TIMING, 1'b0, FAST_B2B, 7'b0};
   assign rd_value = {sts, cmd_q};
   assign cmd      = cmd_q;

   for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt_chk
      // R4
      evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         events[e] |=> evt_q[e]);
      // R4
      evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && be[3] && wdata[EVT_LSB+e] && !events[e]) |=> !evt_q[e]);
      // R4
      evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (evt_q[e] && !(wr_en && be[3] && wdata[EVT_LSB+e])) |=> evt_q[e]);
   end

   // R2
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cmd));

endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile #(
   parameter logic [15:0] VENDOR_ID     = 16'h1D0F,
   parameter logic [15:0] DEVICE_ID     = 16'h7A31,
   parameter logic [7:0]  REVISION_ID   = 8'h05,
   parameter logic [23:0] CLASS_CODE    = 24'h118000,
   parameter logic [7:0]  HEADER_TYPE   = 8'h00,
   parameter logic [7:0]  INT_PIN       = 8'h01,
   parameter logic [7:0]  MIN_GRANT     = 8'h04,
   parameter logic [7:0]  MAX_LATENCY   = 8'h10,
   parameter bit          FAST_B2B      = 1'b1,
   parameter logic [1:0]  SEL_TIMING    = 2'd1,
   parameter logic [35:0] BAR_SIZES     = {6'd16, 6'd0, 6'd20, 6'd0, 6'd8, 6'd12},
   parameter logic [5:0]  BAR_IO        = 6'b000010,
   parameter logic [5:0]  BAR_PREF      = 6'b000001,
   parameter logic [11:0] BAR_LOC       = 12'h000,
   parameter int unsigned ROM_SIZE_CODE = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic         req_write,
   input  logic [5:0]   req_index,
   input  logic [3:0]   req_be,
   input  logic [31:0]  req_wdata,
   output logic         rsp_valid,
   output logic [31:0]  rsp_rdata,
   input  logic         ev_tabort_sent,
   input  logic         ev_tabort_rcvd,
   input  logic         ev_mabort,
   output logic         io_space_en,
   output logic         mem_space_en,
   output logic         parity_resp_en,
   output logic         serr_en,
   output logic         rom_decode_en,
   output logic [31:0]  rom_base_addr,
   output logic [191:0] bar_base_flat
);
   import cfg_hdr_pkg::*;

   initial begin
      assert (VENDOR_ID != 16'hFFFF) else $error("cfg_hdr_regfile: vendor id FFFFh is reserved");
      assert (DEVICE_ID != 16'hFFFF) else $error("cfg_hdr_regfile: device id FFFFh is reserved");
      assert (IDX_W == 6) else $error("cfg_hdr_regfile: index width mismatch");
   end

   logic        wr_acc;
   logic        rd_acc;
   logic [31:0] cs_rd;
   logic [15:0] cmd;
   logic [31:0] rom_rd;
   logic [31:0] bar_rd   [NUM_BARS];
   logic [31:0] bar_base [NUM_BARS];
   logic [NUM_BARS-1:0] bar_sel;
   logic [7:0]  line_q;
   logic [31:0] rd_mux;
   logic        unused_cmd;

   assign wr_acc = req_valid &&  req_write;
   assign rd_acc = req_valid && !req_write;

   cfg_cmd_status #(
      .FAST_B2B   (FAST_B2B),
      .SEL_TIMING (SEL_TIMING)
   ) cmdsts_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_acc && req_index == IX_CMDSTS),
      .be       (req_be),
      .wdata    (req_wdata),
      .events   ({ev_mabort, ev_tabort_rcvd, ev_tabort_sent}),
      .rd_value (cs_rd),
      .cmd      (cmd)
   );

   assign io_space_en    = cmd[0];
   assign mem_space_en   = cmd[1];
   assign parity_resp_en = cmd[6];
   assign serr_en        = cmd[8];
   assign unused_cmd     = ^{cmd[15:9], cmd[7], cmd[5:2]};

   for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
      assign bar_sel[b] = (req_index == IX_BAR0 + IDX_W'(b));
      cfg_bar_slot #(
         .SIZE_LOG2 (int'(BAR_SIZES[b*SZ_W +: SZ_W])),
         .IS_IO     (BAR_IO[b]),
         .PREFETCH  (BAR_PREF[b]),
         .LOC_TYPE  (BAR_LOC[b*2 +: 2])
      ) bar_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_acc && bar_sel[b]),
         .be        (req_be),
         .wdata     (req_wdata),
         .rd_value  (bar_rd[b]),
         .base_addr (bar_base[b])
      );
      assign bar_base_flat[b*32 +: 32] = bar_base[b];
   end

   cfg_rom_slot #(
      .SIZE_CODE (ROM_SIZE_CODE)
   ) rom_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_acc && req_index == IX_ROM),
      .be        (req_be),
      .wdata     (req_wdata),
      .rd_value  (rom_rd),
      .base_addr (rom_base_addr),
      .decode_en (rom_decode_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= '0;
      else if (wr_acc && req_index == IX_INTR && req_be[0]) line_q <= req_wdata[7:0];
   end

   always_comb begin
      rd_mux = '0;
      unique case (req_index)
         IX_IDENT:  rd_mux = {DEVICE_ID, VENDOR_ID};
         IX_CMDSTS: rd_mux = cs_rd;
         IX_CLASS:  rd_mux = {CLASS_CODE, REVISION_ID};
         IX_HDR:    rd_mux = {8'h00, HEADER_TYPE, 16'h0000};
         IX_ROM:    rd_mux = rom_rd;
         IX_INTR:   rd_mux = {MAX_LATENCY, MIN_GRANT, INT_PIN, line_q};
         default: begin
            for (int b = 0; b < NUM_BARS; b++)
               if (bar_sel[b]) rd_mux = bar_rd[b];
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_acc;
         if (rd_acc) rsp_rdata <= rd_mux;
      end
   end

   // R10
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_acc |=> rsp_valid);

   // R10
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_acc |=> !rsp_valid);

   // R9
   reserved_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && req_index > IX_INTR) |=>
         ($stable(rom_base_addr) && $stable(bar_base_flat) && $stable(io_space_en)
          && $stable(mem_space_en)));

   // R7
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_acc && req_index == IX_INTR) |=> $stable(line_q));

endmodule

// File: tb/cfg_hdr_regfile_tb_top.sv
module cfg_hdr_regfile_tb_top;

   localparam logic [15:0] VEN   = 16'h1D0F;
   localparam logic [15:0] DEV   = 16'h7A31;
   localparam logic [7:0]  REV   = 8'h05;
   localparam logic [23:0] CLS   = 24'h118000;
   localparam logic [7:0]  HDR   = 8'h00;
   localparam logic [7:0]  PIN   = 8'h01;
   localparam logic [7:0]  MGNT  = 8'h04;
   localparam logic [7:0]  MLAT  = 8'h10;
   localparam int          ROMC  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [5:0] req_index = '0;
   logic [3:0] req_be = '0;
   logic [31:0] req_wdata = '0;
   logic ev_ts = 1'b0, ev_tr = 1'b0, ev_ma = 1'b0;
   logic rsp_valid;
   logic [31:0] rsp_rdata;
   logic io_en, mem_en, par_en, serr_en_o, rom_en;
   logic [31:0] rom_base;
   logic [191:0] bars;

   always #2 clk = ~clk;

   cfg_hdr_regfile #(
      .VENDOR_ID(VEN), .DEVICE_ID(DEV), .REVISION_ID(REV), .CLASS_CODE(CLS),
      .HEADER_TYPE(HDR), .INT_PIN(PIN), .MIN_GRANT(MGNT), .MAX_LATENCY(MLAT),
      .FAST_B2B(1'b1), .SEL_TIMING(2'd1),
      .BAR_SIZES({6'd16, 6'd0, 6'd20, 6'd0, 6'd8, 6'd12}),
      .BAR_IO(6'b000010), .BAR_PREF(6'b000001), .BAR_LOC(12'h000),
      .ROM_SIZE_CODE(ROMC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_index(req_index), .req_be(req_be), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ev_tabort_sent(ev_ts), .ev_tabort_rcvd(ev_tr), .ev_mabort(ev_ma),
      .io_space_en(io_en), .mem_space_en(mem_en), .parity_resp_en(par_en),
      .serr_en(serr_en_o), .rom_decode_en(rom_en), .rom_base_addr(rom_base),
      .bar_base_flat(bars)
   );

   // reference model state
   int          bsz [6] = '{12, 8, 0, 20, 0, 16};
   bit          bio [6] = '{0, 1, 0, 0, 0, 0};
   bit          bpf [6] = '{1, 0, 0, 0, 0, 0};
   logic [15:0] m_cmd;
   logic [2:0]  m_ev;
   logic [31:0] m_bar [6];
   logic        m_rom_en;
   logic [31:0] m_rom;
   logic [7:0]  m_line;
   logic        exp_valid;
   logic [31:0] exp_data;
   logic [5:0]  exp_idx;
   bit          started = 0;
   int          n_cmp = 0, n_bad = 0;

   function automatic logic [31:0] amask(input int sz);
      if (sz == 0) return 32'h0;
      return 32'hFFFF_FFFF << sz;
   endfunction

   function automatic logic [31:0] bar_attr(input int i);
      if (bsz[i] == 0) return 32'h0;
      if (bio[i]) return 32'h1;
      return bpf[i] ? 32'h8 : 32'h0;
   endfunction

   function automatic logic [31:0] m_read(input logic [5:0] ix);
      logic [15:0] sts;
      sts = {2'b00, m_ev, 2'd1, 1'b0, 1'b1, 7'b0};
      case (ix)
         6'd0:  return {DEV, VEN};
         6'd1:  return {sts, m_cmd};
         6'd2:  return {CLS, REV};
         6'd3:  return {8'h00, HDR, 16'h0};
         6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9:
                return m_bar[ix-4] | bar_attr(int'(ix) - 4);
         6'd12: return m_rom | (32'(ROMC) << 11) | {31'b0, m_rom_en};
         6'd15: return {MLAT, MGNT, PIN, m_line};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] ix);
      case (ix)
         6'd0, 6'd2, 6'd3: return "R1";
         6'd1: return "R2,R3,R4";
         6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9: return "R5";
         6'd12: return "R6";
         6'd15: return "R7";
         default: return "R9";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd = '0; m_ev = '0; m_rom_en = 1'b0; m_rom = '0; m_line = '0;
         for (int i = 0; i < 6; i++) m_bar[i] = '0;
         exp_valid = 1'b0;
      end else begin
         logic [31:0] bm, am;
         exp_valid = req_valid && !req_write;
         exp_idx   = req_index;
         if (exp_valid) exp_data = m_read(req_index);
         for (int l = 0; l < 4; l++) bm[l*8 +: 8] = {8{req_be[l]}};
         if (req_valid && req_write) begin
            case (req_index)
               6'd1: begin
                  am = bm & 32'h0000_036B;
                  m_cmd = (m_cmd & ~am[15:0]) | (req_wdata[15:0] & am[15:0]);
                  if (req_be[3]) m_ev = m_ev & ~req_wdata[29:27];
               end
               6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9: begin
                  am = bm & amask(bsz[req_index-4]);
                  m_bar[req_index-4] = (m_bar[req_index-4] & ~am) | (req_wdata & am);
               end
               6'd12: begin
                  am = bm & amask(15 + ROMC);
                  m_rom = (m_rom & ~am) | (req_wdata & am);
                  if (req_be[0]) m_rom_en = req_wdata[0];
               end
               6'd15: if (req_be[0]) m_line = req_wdata[7:0];
               default: ;
            endcase
         end
         m_ev = m_ev | {ev_ma, ev_tr, ev_ts};
      end
   end

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         cmp("R10 rsp_valid", 32'(rsp_valid), 32'(exp_valid));
         if (exp_valid) cmp(tag_of(exp_idx), rsp_rdata, exp_data);
         cmp("R2 io_space_en", 32'(io_en), 32'(m_cmd[0]));
         cmp("R2 mem_space_en", 32'(mem_en), 32'(m_cmd[1]));
         cmp("R2 parity_resp_en", 32'(par_en), 32'(m_cmd[6]));
         cmp("R2 serr_en", 32'(serr_en_o), 32'(m_cmd[8]));
         cmp("R6 rom_decode_en", 32'(rom_en), 32'(m_rom_en));
         cmp("R6 rom_base_addr", rom_base, m_rom);
         for (int i = 0; i < 6; i++) cmp("R12 bar_base", bars[i*32 +: 32], m_bar[i]);
      end
   end

   task automatic op(input bit w, input logic [5:0] ix, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_index = ix; req_be = be; req_wdata = d;
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      req_valid = 1'b0; ev_ts = 0; ev_tr = 0; ev_ma = 0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic read_all();
      for (int i = 0; i < 64; i++) op(0, 6'(i), 4'h0, 32'h0);
      idle(2);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [31:0] lf;
      lf = 32'hACE1_2357;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      started = 1;
      // R11 reset state: full readback, R1 and R3 fixed fields included
      read_all();
      // R5 R6 size probe: all ones everywhere, also R9 reserved writes
      for (int i = 0; i < 64; i++) op(1, 6'(i), 4'hF, 32'hFFFF_FFFF);
      idle(2);
      read_all();
      // R4 events, set and hold
      @(negedge clk); ev_ts = 1; ev_ma = 1;
      idle(2);
      op(0, 6'd1, 4'h0, 0);
      // R4 clear with lane 3 off: no effect; writing zeros: no effect
      op(1, 6'd1, 4'h7, 32'h3800_0000);
      op(1, 6'd1, 4'h8, 32'h0000_0000);
      op(0, 6'd1, 4'h0, 0);
      // R4 clear and set same cycle: event wins for bit 11
      op(1, 6'd1, 4'h8, 32'h3800_0000); ev_ts = 1;
      idle(1);
      op(0, 6'd1, 4'h0, 0);
      // R8 partial lanes on a BAR and the ROM
      op(1, 6'd7, 4'h4, 32'h00AB_0000);
      op(1, 6'd7, 4'h9, 32'h5500_0000);
      op(1, 6'd12, 4'h1, 32'h0000_0000);
      op(0, 6'd7, 4'h0, 0);
      op(0, 6'd12, 4'h0, 0);
      // R7 interrupt lane
      op(1, 6'd15, 4'hE, 32'h1234_5600);
      op(0, 6'd15, 4'h0, 0);
      op(1, 6'd15, 4'h1, 32'h0000_003C);
      op(0, 6'd15, 4'h0, 0);
      idle(2);
      // random traffic for R2 R5 R6 R8 R9 R10 R12
      for (int k = 0; k < 3000; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         @(negedge clk);
         req_valid = lf[0] | lf[1];
         req_write = lf[2];
         req_index = lf[3] ? {2'b00, lf[7:4]} : lf[13:8];
         req_be    = lf[17:14];
         req_wdata = {lf[15:0], lf[31:16]} ^ {32{lf[18]}};
         ev_ts = (lf[22:19] == 4'h0);
         ev_tr = (lf[25:22] == 4'h5);
         ev_ma = (lf[28:25] == 4'hA);
      end
      idle(2);
      read_all();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule